// File: doc/BRIEF.md
# Multi-Sample ADC Code Combiner

This block turns the digital output of a two-stage column converter into one noise-cancelled pixel value. The converter samples each pixel level many times: 32 samples go into an integrating coarse stage, and a cyclic stage then resolves the analog residue. For every level the block receives a 5-bit coarse code and a 13-bit fine code, together with a flag that says whether the level is the reset level or the signal level.

The two codes overlap by one bit. The block joins them by shifting the coarse code up by twelve places and adding the fine code. The adder has one spare bit, so a carry out of the overlap is kept, and the merged value is then limited to the 17-bit range. The merged reset code is held until the matching signal code arrives. The block then subtracts reset from signal, which is correlated multiple sampling done in the digital domain. A negative difference gives zero. The result leaves the block on a registered port with a valid pulse that lasts one cycle. If a signal code arrives with no reset code waiting, the block raises an order-error pulse instead of a result.

Top module: `cms_code_combiner`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `res_vld` and `seq_err` are 0 and `res_code` is 0.
- R2: A level's merged code equals coarse × 4096 + fine. The coarse code occupies bits 16..12 and shares bit 12 with the top bit of the 13-bit fine code, so a fine code of 4096 or more carries into the coarse bits.
- R3: A merged code whose sum is above 131071 is limited to 131071.
- R4: A strobe with `code_vld`=1 and `code_is_sig`=1 that arrives while a reset code is pending sets `res_vld` to 1 for the single cycle after its clock edge, with `res_code` = merged signal − merged reset.
- R5: When the merged signal code is below the merged reset code, `res_code` is 0 and `res_vld` still pulses.
- R6: A signal strobe that arrives with no reset code pending raises `seq_err` for one cycle after its edge. `res_vld` stays 0 and `res_code` keeps its previous value.
- R7: A signal strobe uses up the pending reset code, so a second signal strobe gives `seq_err`. A reset strobe that arrives while a reset code is already pending replaces the stored code.
- R8: A reset strobe (`code_vld`=1, `code_is_sig`=0) produces no `res_vld` and leaves `res_code` unchanged.
- R9: `res_vld` is never high on two cycles in a row, and `res_vld` and `seq_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| code_vld | input | 1 | A coarse/fine code pair is present this cycle |
| code_is_sig | input | 1 | 1 = signal level, 0 = reset level |
| coarse_code | input | 5 | Code from the folding-integration stage |
| fine_code | input | 13 | Code from the cyclic residue stage |
| res_vld | output | 1 | One-cycle pulse: `res_code` holds a new result |
| res_code | output | 17 | Registered, clamped signal − reset difference |
| seq_err | output | 1 | One-cycle pulse: signal code arrived with no reset pending |

## Verification
The assertions assume that each strobe is a single cycle of `code_vld` carrying a clean `code_is_sig` value. They also assume that any result or error comes from a signal strobe on the cycle before, so nothing is produced spontaneously. The directed stimulus drives one strobe and then one idle cycle, so every outcome can be tied to one strobe. The error cases are built on purpose from the legal strobe shapes: an orphan signal, a repeated signal, and a replaced reset.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  localparam int unsigned CMC_CRS_W = 5;
  localparam int unsigned CMC_FIN_W = 13;
  localparam int unsigned CMC_OVL_W = 1;
endpackage

// File: rtl/cmc_merge.sv
module cmc_merge #(
  parameter int unsigned CRS_W = cmc_pkg::CMC_CRS_W,
  parameter int unsigned FIN_W = cmc_pkg::CMC_FIN_W,
  parameter int unsigned OVL_W = cmc_pkg::CMC_OVL_W,
  localparam int unsigned OUT_W = CRS_W + FIN_W - OVL_W
) (
  input  logic [CRS_W-1:0] coarse,
  input  logic [FIN_W-1:0] fine,
  output logic [OUT_W-1:0] merged
);
  localparam int unsigned SHIFT = FIN_W - OVL_W;
  localparam int unsigned SUM_W = OUT_W + 1;

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = (SUM_W'(coarse) << SHIFT) + SUM_W'(fine);
  end

  generate
    if (OVL_W == 0) begin : g_no_ovl
      assign merged = sum[OUT_W-1:0];
    end else begin : g_sat
      assign merged = sum[SUM_W-1] ? {OUT_W{1'b1}} : sum[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/cmc_pair_track.sv
module cmc_pair_track #(
  parameter int unsigned OUT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rst_stb,
  input  logic             sig_stb,
  input  logic [OUT_W-1:0] code_in,
  output logic [OUT_W-1:0] held_rst,
  output logic             pair_ok,
  output logic             order_bad
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      held_rst <= '0;
    end else if (rst_stb) begin
      armed    <= 1'b1;
      held_rst <= code_in;
    end else if (sig_stb) begin
      armed    <= 1'b0;
    end
  end

  assign pair_ok   = sig_stb & armed;
  assign order_bad = sig_stb & ~armed;

  // R7
  consume_chk: assert property (@(posedge clk) disable iff (rst)
    (sig_stb && !rst_stb) |=> !armed);
endmodule

// File: rtl/cmc_diff_out.sv
module cmc_diff_out #(
  parameter int unsigned OUT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pair_ok,
  input  logic             order_bad,
  input  logic [OUT_W-1:0] sig_code,
  input  logic [OUT_W-1:0] ref_code,
  output logic             res_vld,
  output logic [OUT_W-1:0] res_code,
  output logic             seq_err
);
  logic [OUT_W:0]   diff;
  logic [OUT_W-1:0] clamped;

  always_comb begin
    diff    = {1'b0, sig_code} - {1'b0, ref_code};
    clamped = diff[OUT_W] ? '0 : diff[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld  <= 1'b0;
      seq_err  <= 1'b0;
      res_code <= '0;
    end else begin
      res_vld <= pair_ok;
      seq_err <= order_bad;
      if (pair_ok) res_code <= clamped;
    end
  end

  // R5
  clamp_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pair_ok && (sig_code < ref_code)) |=> (res_code == '0));
  // R6
  hold_on_err_chk: assert property (@(posedge clk) disable iff (rst)
    seq_err |-> $stable(res_code));
endmodule

// File: rtl/cms_code_combiner.sv
module cms_code_combiner #(
  parameter int unsigned CRS_W = cmc_pkg::CMC_CRS_W,
  parameter int unsigned FIN_W = cmc_pkg::CMC_FIN_W,
  parameter int unsigned OVL_W = cmc_pkg::CMC_OVL_W,
  localparam int unsigned OUT_W = CRS_W + FIN_W - OVL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             code_vld,
  input  logic             code_is_sig,
  input  logic [CRS_W-1:0] coarse_code,
  input  logic [FIN_W-1:0] fine_code,
  output logic             res_vld,
  output logic [OUT_W-1:0] res_code,
  output logic             seq_err
);
  logic             rst_stb, sig_stb;
  logic [OUT_W-1:0] merged, held_rst;
  logic             pair_ok, order_bad;

  assign rst_stb = code_vld & ~code_is_sig;
  assign sig_stb = code_vld & code_is_sig;

  cmc_merge #(.CRS_W(CRS_W), .FIN_W(FIN_W), .OVL_W(OVL_W)) u_merge (
    .coarse (coarse_code),
    .fine   (fine_code),
    .merged (merged)
  );

  cmc_pair_track #(.OUT_W(OUT_W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .rst_stb   (rst_stb),
    .sig_stb   (sig_stb),
    .code_in   (merged),
    .held_rst  (held_rst),
    .pair_ok   (pair_ok),
    .order_bad (order_bad)
  );

  cmc_diff_out #(.OUT_W(OUT_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .pair_ok   (pair_ok),
    .order_bad (order_bad),
    .sig_code  (merged),
    .ref_code  (held_rst),
    .res_vld   (res_vld),
    .res_code  (res_code),
    .seq_err   (seq_err)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!res_vld && !seq_err && res_code == '0));
  // R4
  vld_cause_chk: assert property (@(posedge clk) disable iff (rst)
    res_vld |-> $past(code_vld && code_is_sig));
  // R6
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    seq_err |-> $past(code_vld && code_is_sig));
  // R8
  rst_stb_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (code_vld && !code_is_sig) |=> (!res_vld && !seq_err && $stable(res_code)));
  // R9
  vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_vld |=> !res_vld);
  // R9
  excl_out_chk: assert property (@(posedge clk) disable iff (rst)
    !(res_vld && seq_err));
  // R2
  merge_low_chk: assert property (@(posedge clk) disable iff (rst)
    (code_vld && coarse_code == '0) |-> (merged == OUT_W'(fine_code)));
endmodule

// File: tb/sim_cms_code_combiner.sv
`timescale 1ns/1ps
module sim_cms_code_combiner;
  logic        clk = 1'b0;
  logic        rst;
  logic        code_vld, code_is_sig;
  logic [4:0]  coarse_code;
  logic [12:0] fine_code;
  logic        res_vld, seq_err;
  logic [16:0] res_code;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  cms_code_combiner u0 (
    .clk(clk), .rst(rst), .code_vld(code_vld), .code_is_sig(code_is_sig),
    .coarse_code(coarse_code), .fine_code(fine_code),
    .res_vld(res_vld), .res_code(res_code), .seq_err(seq_err)
  );

  function automatic int model_merge(input int c, input int f);
    int v;
    v = c * 4096 + f;
    if (v > 131071) v = 131071;
    return v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one strobe, outputs sampled on the falling edge after the capturing edge
  task automatic strobe(input bit sig, input int c, input int f,
                        output bit v, output bit e, output int code);
    @(negedge clk);
    code_vld = 1'b1; code_is_sig = sig;
    coarse_code = 5'(c); fine_code = 13'(f);
    @(negedge clk);
    code_vld = 1'b0;
    v = res_vld; e = seq_err; code = int'(res_code);
  endtask

  task automatic t_reset;
    check("R1 res_vld", int'(res_vld), 0);
    check("R1 seq_err", int'(seq_err), 0);
    check("R1 res_code", int'(res_code), 0);
  endtask

  task automatic t_pair(input string req, input int rc, input int rf,
                        input int sc, input int sf);
    bit v, e; int code; int s, r, exp;
    strobe(1'b0, rc, rf, v, e, code);
    s = model_merge(sc, sf); r = model_merge(rc, rf);
    exp = (s > r) ? s - r : 0;
    strobe(1'b1, sc, sf, v, e, code);
    check({req, " res_vld"}, int'(v), 1);
    check({req, " seq_err"}, int'(e), 0);
    check({req, " res_code"}, code, exp);
    @(negedge clk);
    check({req, " R9 pulse ends"}, int'(res_vld), 0);
  endtask

  task automatic t_orphan;
    bit v, e; int code; int prev;
    prev = int'(res_code);
    strobe(1'b1, 9, 100, v, e, code);
    check("R6 seq_err", int'(e), 1);
    check("R6 no res_vld", int'(v), 0);
    check("R6 res_code held", code, prev);
    @(negedge clk);
    check("R6 err pulse ends", int'(seq_err), 0);
  endtask

  task automatic t_consume;
    bit v, e; int code;
    strobe(1'b0, 1, 0, v, e, code);
    strobe(1'b1, 2, 0, v, e, code);
    check("R7 first signal", code, 4096);
    strobe(1'b1, 3, 0, v, e, code);
    check("R7 second signal seq_err", int'(e), 1);
    check("R7 second signal no vld", int'(v), 0);
  endtask

  task automatic t_replace;
    bit v, e; int code; int prev;
    strobe(1'b0, 10, 0, v, e, code);
    prev = int'(res_code);
    strobe(1'b0, 2, 7, v, e, code);
    check("R8 reset strobe no vld", int'(v), 0);
    check("R8 reset strobe code held", code, prev);
    strobe(1'b1, 4, 7, v, e, code);
    check("R7 replaced reset used", code, 2 * 4096);
  endtask

  initial begin : wdog
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; code_vld = 1'b0; code_is_sig = 1'b0;
    coarse_code = '0; fine_code = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pair("R4 basic", 1, 200, 6, 1234);
    t_pair("R2 overlap carry", 0, 10, 3, 5000);
    t_pair("R2 zero coarse", 0, 0, 0, 8191);
    t_pair("R3 saturate", 0, 0, 31, 8191);
    t_pair("R3 saturate both", 31, 4095, 31, 8191);
    t_pair("R5 clamp", 7, 100, 2, 50);
    t_pair("R5 equal", 4, 4, 4, 4);
    t_orphan();
    t_consume();
    t_replace();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule